// File: doc/BRIEF.md
# Operate Microinstruction Execution Unit

This block carries out the register-only operate group of a 16-bit accumulator machine. On each accepted strobe it takes an instruction word, the present accumulator and link values and the data-switch word. It then writes the updated accumulator and link into its output registers. All micro-operation bits in one word act within a single cycle. They always act in a fixed sequence: clearing first, then inverting, then incrementing, and last the switch merge. As a result, some bit combinations give useful composite results, such as all ones or two's-complement negation.

The unit also keeps a run flag. A word whose top bit is clear acts as a halt: its micro-operation bits still take effect, and then the run flag drops. The flag rises again only when the start input is pulsed. A word that does not belong to the operate group raises an illegal indication and leaves the registers as they were. Every accepted strobe produces a done pulse, and a legal operate word reports a cost of one cycle.

Top module: `opr_unit`

## Requirements
- R1: After reset, acc_q is 0, link_q is 0, running is 0, done is 0, illegal is 0 and cost is 0.
- R2: A pulse on start sets running in the next cycle. While running is 0, a valid strobe is ignored: there is no done pulse, and acc_q and link_q keep their values.
- R3: A word is an operate word when instr[14:6] are all zero. For any other accepted word, illegal is 1 alongside done, cost is 0, and acc_q and link_q are unchanged.
- R4: The first phase works as follows. instr[0] clears the accumulator and instr[3] clears the link.
- R5: The second phase acts on the result of the first. instr[1] replaces the accumulator with its ones' complement and instr[4] inverts the link, so code 000003 (octal) gives all ones.
- R6: The third phase acts on the result of the second. instr[2] adds one to the accumulator, and a carry out of the top bit inverts the link rather than being copied into it. Code 000006 therefore gives the negated accumulator.
- R7: After the increment, instr[5] ORs the data-switch word into the accumulator.
- R8: An operate word with instr[15] = 0 applies its micro-operation bits and then clears running. running stays 0 until start is pulsed.
- R9: done is 1 in the cycle after each accepted strobe (valid while running) and 0 otherwise. cost is 1 with done for a legal operate word.
- R10: Without an accepted strobe, acc_q and link_q hold their values whatever acc_in, link_in and sw do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sets the run flag |
| valid | input | 1 | Strobe: execute instr this cycle |
| instr | input | 16 | Instruction word |
| acc_in | input | W | Current accumulator |
| link_in | input | 1 | Current link |
| sw | input | W | Data-switch word |
| acc_q | output | W | Updated accumulator |
| link_q | output | 1 | Updated link |
| running | output | 1 | Run flag |
| illegal | output | 1 | Accepted word was outside the operate group |
| done | output | 1 | Strobe was accepted in the previous cycle |
| cost | output | 2 | Cycles used by the finished operate word |

## Verification
The bench builds the unit with its default width W = 16, which matches the 16-bit instruction word. At this width, a random accumulator of all ones reaches the carry-toggle of the link. Random words restricted to the operate group mix all six micro-operation bits and the halt bit. Directed words cover all-ones loading, negation of zero with its link toggle, the increment-then-merge order, halting with bits set, and restart.

// File: rtl/opr_unit.sv
module opr_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         valid,
  input  logic [15:0]  instr,
  input  logic [W-1:0] acc_in,
  input  logic         link_in,
  input  logic [W-1:0] sw,
  output logic [W-1:0] acc_q,
  output logic         link_q,
  output logic         running,
  output logic         illegal,
  output logic         done,
  output logic [1:0]   cost
);
  localparam int TOP = W - 1;

  logic         is_opr, take;
  logic [W-1:0] a1, a2, a3;
  logic         l1, l2, l3;
  logic [W:0]   inc;

  assign is_opr = (instr[14:6] == 9'd0);
  assign take   = valid & running;

  assign a1  = instr[0] ? '0 : acc_in;
  assign l1  = instr[3] ? 1'b0 : link_in;
  assign a2  = instr[1] ? ~a1 : a1;
  assign l2  = instr[4] ? ~l1 : l1;
  assign inc = {1'b0, a2} + {{W{1'b0}}, 1'b1};
  assign l3  = l2 ^ (instr[2] & inc[W]);
  assign a3  = (instr[2] ? inc[TOP:0] : a2) | (instr[5] ? sw : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      link_q  <= 1'b0;
      running <= 1'b0;
      illegal <= 1'b0;
      done    <= 1'b0;
      cost    <= 2'd0;
    end else begin
      done    <= take;
      illegal <= take & ~is_opr;
      cost    <= (take & is_opr) ? 2'd1 : 2'd0;
      if (take & is_opr) begin
        acc_q  <= a3;
        link_q <= l3;
      end
      if (start)
        running <= 1'b1;
      else if (take & is_opr & ~instr[15])
        running <= 1'b0;
    end
  end
endmodule

module opr_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         valid,
  input logic [15:0]  instr,
  input logic [W-1:0] acc_q,
  input logic         link_q,
  input logic         running,
  input logic         illegal,
  input logic         done,
  input logic [1:0]   cost
);
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running);
  a_r2_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !running) |=> (!done && $stable(acc_q) && $stable(link_q)));
  a_r3_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && running && instr[14:6] != 9'd0) |=> (illegal && cost == 2'd0 && $stable(acc_q) && $stable(link_q)));
  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && running && instr[14:6] == 9'd0 && !instr[15] && !start) |=> !running);
  a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && running) |=> done);
  a_r9_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && running) |=> !done);
  a_r9_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> cost == 2'd1);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && running) |=> ($stable(acc_q) && $stable(link_q)));
endmodule

bind opr_unit opr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .instr(instr),
  .acc_q(acc_q), .link_q(link_q), .running(running), .illegal(illegal),
  .done(done), .cost(cost)
);

// File: tb/opr_unit_bench.sv
`timescale 1ns/1ps
module opr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [15:0] sw = '0;
  logic [15:0] acc_q;
  logic        link_q, running, illegal, done;
  logic [1:0]  cost;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] e_acc = '0;
  logic        e_link = 1'b0;
  logic        e_run = 1'b0;

  always #4 clk = ~clk;

  opr_unit #(.W(16)) u_opr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .instr(instr),
    .acc_in(acc_in), .link_in(link_in), .sw(sw), .acc_q(acc_q),
    .link_q(link_q), .running(running), .illegal(illegal), .done(done),
    .cost(cost)
  );

  function automatic logic [16:0] model(input logic [15:0] ins, input logic [15:0] a,
                                        input logic l, input logic [15:0] s);
    int unsigned x = a;
    bit lk = l;
    if (ins[0]) x = 0;
    if (ins[3]) lk = 0;
    if (ins[1]) x = (~x) & 32'hFFFF;
    if (ins[4]) lk = ~lk;
    if (ins[2]) begin
      x = x + 1;
      if (x > 32'hFFFF) begin
        lk = ~lk;
        x = x & 32'hFFFF;
      end
    end
    if (ins[5]) x = x | s;
    return {lk, x[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit e_done, input bit e_ill, input logic [1:0] e_cost);
    chk(done == e_done, tag, "done", {31'd0, done}, {31'd0, e_done});
    chk(illegal == e_ill, tag, "illegal", {31'd0, illegal}, {31'd0, e_ill});
    chk(cost == e_cost, tag, "cost", {30'd0, cost}, {30'd0, e_cost});
    chk(acc_q == e_acc, tag, "acc", {16'd0, acc_q}, {16'd0, e_acc});
    chk(link_q == e_link, tag, "link", {31'd0, link_q}, {31'd0, e_link});
    chk(running == e_run, tag, "running", {31'd0, running}, {31'd0, e_run});
  endtask

  task automatic run_op(input logic [15:0] ins, input logic [15:0] a, input logic l,
                        input logic [15:0] s, input string tag);
    bit took, legal;
    logic [16:0] r;
    @(negedge clk);
    instr = ins; acc_in = a; link_in = l; sw = s; valid = 1'b1;
    took  = e_run;
    legal = (ins[14:6] == 9'd0);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    if (took && legal) begin
      r = model(ins, a, l, s);
      e_acc = r[15:0];
      e_link = r[16];
      if (!ins[15]) e_run = 1'b0;
    end
    check_all(tag, took, took && !legal, (took && legal) ? 2'd1 : 2'd0);
  endtask

  task automatic pulse_start(input string tag);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    e_run = 1'b1;
    chk(running == 1'b1, tag, "running after start", {31'd0, running}, 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1", 1'b0, 1'b0, 2'd0);

    run_op(16'o100001, 16'h1234, 1'b1, 16'h0, "R2");
    pulse_start("R2");

    run_op(16'o100003, 16'h5A5A, 1'b0, 16'h0, "R5");
    run_op(16'o100020, 16'h0001, 1'b0, 16'h0, "R5");
    run_op(16'o100011, 16'hBEEF, 1'b1, 16'h0, "R4");
    run_op(16'o100006, 16'h0005, 1'b0, 16'h0, "R6");
    run_op(16'o100006, 16'h0000, 1'b0, 16'h0, "R6");
    run_op(16'o100004, 16'hFFFF, 1'b1, 16'h0, "R6");
    run_op(16'o100044, 16'hFFFF, 1'b0, 16'h00F0, "R7");
    run_op(16'o100040, 16'h0F00, 1'b0, 16'h00F0, "R7");
    run_op(16'o100100, 16'h7777, 1'b1, 16'h0, "R3");
    run_op(16'o077777, 16'h7777, 1'b1, 16'h0, "R3");

    @(negedge clk);
    acc_in = 16'hAAAA; link_in = ~e_link; sw = 16'hFFFF; instr = 16'o100077;
    @(negedge clk);
    check_all("R10", 1'b0, 1'b0, 2'd0);

    run_op(16'o000001, 16'h1234, 1'b1, 16'h0, "R8");
    run_op(16'o100002, 16'h1234, 1'b0, 16'h0, "R8");
    pulse_start("R8");
    run_op(16'o000000, 16'h4321, 1'b1, 16'h0, "R8");
    pulse_start("R8");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] ins;
      int unsigned pick = $urandom_range(0, 9);
      if (pick == 0)
        ins = 16'($urandom);
      else
        ins = {(pick != 1), 9'd0, 6'($urandom)};
      run_op(ins, 16'($urandom), 1'($urandom), 16'($urandom), "R9");
      if (!e_run) pulse_start("R8");
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule